// File: doc/BRIEF.md
# Performance Counter Bank

A bank of event counters and one 64-bit cycle counter that sits beside a processor core. Software reaches it through a simple word-addressed read/write port: one request per cycle, a write completes in the cycle it is presented, and a read answers exactly one cycle later. Event pulses arrive on a vector indexed by event number. Each implemented event counter selects one event, can skip a privilege level through two exclude bits, and counts one per cycle in which its event is high. The interrupt output is raised while any counter has both its overflow-status bit and its interrupt-enable bit set.

Per-counter state lives in three bitmaps: counter enable, interrupt enable and overflow status. Each has a set view and a clear view, and bit 31 always belongs to the cycle counter. A global control word holds the master enable, the long-cycle mode and two self-clearing reset actions. A selector register picks one event counter, whose type and count can then be reached indirectly. Every counter can also be reached at its own direct address.

The read port is run by a two-state machine. ACC_IDLE means no response is pending. A read request moves it to ACC_RESP, and any other cycle keeps it in ACC_IDLE. ACC_RESP presents the captured read data with `rsp_valid` high. From ACC_RESP, another read request keeps it in ACC_RESP, and no read request returns it to ACC_IDLE.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, the control word (word address 0x00) reads only the implemented-counter count N in bits 15:11. All bitmaps and all counters read 0, and `irq` is low.
- R2: Control bit 0 (global enable) and bit 6 (long-cycle) read back as last written. Bits 1 and 2 always read 0. Every other bit outside the N field reads 0 whatever is written.
- R3: The counter-enable bitmap has a set view at 0x01 and a clear view at 0x02. Writing 1s to the set view enables counters, and writing 1s to the clear view disables them. Both views read the same bitmap. Bit 31 is the cycle counter and bits 0..N-1 are the event counters. Writes to any other bit are ignored, and those bits read 0.
- R4: The interrupt-enable bitmap (set view 0x03, clear view 0x04) and the overflow-status bitmap (set view 0x05, clear view 0x06) follow the same scheme as R3. Writing all ones to a clear view makes it read 0.
- R5: An event counter increments by one per clock in which its selected event input is high, and only while the global enable and its own enable bit are both 1.
- R6: An event counter that increments past 0xFFFFFFFF wraps to 0 and sets only its own overflow-status bit. A hardware overflow set wins over a software clear in the same cycle.
- R7: `irq` is the OR over all counters of (overflow status AND interrupt enable). It stays high until software clears the status bits.
- R8: The selector at 0x07 takes counter index bits 4:0. The selected counter's type is at 0x08 and its count is at 0x09. Counter i's type is also at 0x20+i and its count at 0x40+i, and both paths show the same registers. An index with no implemented counter reads 0, and writes to it are dropped.
- R9: The type word holds the event number in bits 9:0, exclude-user in bit 30 and exclude-kernel in bit 31. Bits 29:10 read 0. When `priv_kernel` is 0 the exclude-user bit blocks counting, and when it is 1 the exclude-kernel bit does.
- R10: An event number of NUM_EVT or above never counts. The counter's count register still accepts writes and returns the written value.
- R11: A control write with bit 1 set zeroes all event counters, and one with bit 2 set zeroes the cycle counter. The zeroing takes effect in that write cycle and overrides any count there.
- R12: The 64-bit cycle counter (low half 0x0A, high half 0x0B) adds one every clock while the global enable and bitmap bit 31 are both 1. It sets overflow bit 31 at the 32-bit wrap when long-cycle is 0, and only at the 64-bit wrap when long-cycle is 1.
- R13: `rsp_valid` is high exactly in the cycle after a read request, carrying the register value as it was in the request cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| evt_in | input | NUM_EVT | Event pulses indexed by event number |
| priv_kernel | input | 1 | Current privilege: 1 = kernel, 0 = user |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check, on every cycle, the properties that hold locally. A set or clear write takes effect in the bitmap by the next cycle. An idle counter holds its value. A counter wrap lands on zero. A reset action zeroes the counters. A response follows exactly one read request. Clearing all status bits drops the interrupt. Only the bench scenarios can show the end-to-end behaviour: exact event counts under the two enables, an overflow confined to one counter, and exclude filtering that flips with the privilege input. They also cover indirect and direct access agreeing, unimplemented bits reading 0, and the cycle counter's choice between the 32-bit and 64-bit wrap.

// File: rtl/pmu_bank_pkg.sv
package pmu_bank_pkg;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 7;
    localparam int MAX_CNT = 31;
    localparam int EVT_NUM_W = 10;

    localparam logic [ADDR_W-1:0] A_CTRL     = 7'h00;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 7'h01;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 7'h02;
    localparam logic [ADDR_W-1:0] A_IE_SET   = 7'h03;
    localparam logic [ADDR_W-1:0] A_IE_CLR   = 7'h04;
    localparam logic [ADDR_W-1:0] A_OVF_SET  = 7'h05;
    localparam logic [ADDR_W-1:0] A_OVF_CLR  = 7'h06;
    localparam logic [ADDR_W-1:0] A_SEL      = 7'h07;
    localparam logic [ADDR_W-1:0] A_SEL_TYPE = 7'h08;
    localparam logic [ADDR_W-1:0] A_SEL_CNT  = 7'h09;
    localparam logic [ADDR_W-1:0] A_CYC_LO   = 7'h0A;
    localparam logic [ADDR_W-1:0] A_CYC_HI   = 7'h0B;
    localparam logic [1:0] REGION_TYPE = 2'b01;
    localparam logic [1:0] REGION_CNT  = 2'b10;

    localparam int CB_EN     = 0;
    localparam int CB_EVRST  = 1;
    localparam int CB_CYRST  = 2;
    localparam int CB_LONG   = 6;

    localparam logic [REG_W-1:0] TYPE_KEEP = 32'hC000_03FF;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;
endpackage

// File: rtl/pmu_bitmap.sv
module pmu_bitmap #(
    parameter int W = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] sw_set, sw_clr, q_d;

    always_comb begin
        sw_set = set_we ? wdata : '0;
        sw_clr = clr_we ? wdata : '0;
        // hardware set has priority over a same-cycle clear
        q_d = (((q | sw_set) & ~sw_clr) | hw_set) & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    // R3 / R4: a set write is visible next cycle
    assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));

    // R4: a clear write removes the bits unless hardware set them
    assert_clear_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(wdata & ~hw_set)) == '0));
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
    import pmu_bank_pkg::*;
#(
    parameter int NUM_EVT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               type_we,
    input  logic [REG_W-1:0]   type_wval,
    input  logic               cnt_we,
    input  logic [REG_W-1:0]   cnt_wval,
    input  logic               clr,
    input  logic               active,
    input  logic               priv_kernel,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [REG_W-1:0]   type_q,
    output logic [REG_W-1:0]   count_q,
    output logic               ovf_pulse
);
    logic [EVT_NUM_W-1:0] evt_num;
    logic hit, excluded, inc;

    assign evt_num = type_q[EVT_NUM_W-1:0];

    always_comb begin
        hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (evt_num == EVT_NUM_W'(e)) hit = evt_in[e];
        end
    end

    assign excluded  = priv_kernel ? type_q[31] : type_q[30];
    assign inc       = active && hit && !excluded && !clr && !cnt_we;
    assign ovf_pulse = inc && (count_q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q  <= '0;
            count_q <= '0;
        end else begin
            if (type_we) type_q <= type_wval;
            if (clr)         count_q <= '0;
            else if (cnt_we) count_q <= cnt_wval;
            else if (inc)    count_q <= count_q + 1'b1;
        end
    end

    // R5: a counter that is not active and not written holds its value
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr && !cnt_we) |=> $stable(count_q));

    // R6: an overflow leaves the counter at zero
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (count_q == '0));

    // R11: the reset action zeroes the count
    assert_evt_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter
    import pmu_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [REG_W-1:0] wval,
    input  logic             active,
    input  logic             long_mode,
    output logic [2*REG_W-1:0] cnt_q,
    output logic             ovf_pulse
);
    logic inc, lo_full, all_full;

    assign lo_full   = (cnt_q[REG_W-1:0] == '1);
    assign all_full  = (cnt_q == '1);
    assign inc       = active && !clr && !lo_we && !hi_we;
    assign ovf_pulse = inc && (long_mode ? all_full : lo_full);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (lo_we) begin
            cnt_q[REG_W-1:0] <= wval;
        end else if (hi_we) begin
            cnt_q[2*REG_W-1:REG_W] <= wval;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R12: in long mode the overflow is the full 64-bit wrap
    assert_cyc_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && long_mode) |=> (cnt_q == '0));

    // R11: the cycle reset action zeroes the counter
    assert_cyc_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
    import pmu_bank_pkg::*;
#(
    parameter int NUM_CNT = 6,
    parameter int NUM_EVT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [REG_W-1:0]   req_wdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               priv_kernel,
    output logic               rsp_valid,
    output logic [REG_W-1:0]   rsp_rdata,
    output logic               irq
);
    localparam logic [REG_W-1:0] EVT_MASK  = REG_W'((64'd1 << NUM_CNT) - 64'd1);
    localparam logic [REG_W-1:0] IMPL_MASK = EVT_MASK | 32'h8000_0000;
    localparam logic [4:0]       N_FIELD   = 5'(NUM_CNT);

    // ---------------- write decode ----------------
    logic wr, rd_req;
    logic wr_ctrl, ev_clr, cy_clr;
    logic [REG_W-1:0] typ_wval;

    assign wr       = req_valid && req_write;
    assign rd_req   = req_valid && !req_write;
    assign wr_ctrl  = wr && (req_addr == A_CTRL);
    assign ev_clr   = wr_ctrl && req_wdata[CB_EVRST];
    assign cy_clr   = wr_ctrl && req_wdata[CB_CYRST];
    assign typ_wval = req_wdata & TYPE_KEEP;

    // ---------------- control and selector ----------------
    logic       glob_en, long_cyc;
    logic [4:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en  <= 1'b0;
            long_cyc <= 1'b0;
            sel_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                glob_en  <= req_wdata[CB_EN];
                long_cyc <= req_wdata[CB_LONG];
            end
            if (wr && (req_addr == A_SEL)) sel_q <= req_wdata[4:0];
        end
    end

    // ---------------- bitmaps ----------------
    logic [REG_W-1:0] en_q, ie_q, ovf_q, hw_ovf;
    logic [MAX_CNT-1:0] ovf_ev;
    logic cyc_ovf;

    assign hw_ovf = {cyc_ovf, ovf_ev};

    pmu_bitmap #(.W(REG_W), .MASK(IMPL_MASK)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr && (req_addr == A_EN_SET)),
        .clr_we(wr && (req_addr == A_EN_CLR)),
        .wdata(req_wdata), .hw_set('0), .q(en_q)
    );

    pmu_bitmap #(.W(REG_W), .MASK(IMPL_MASK)) u_ie (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr && (req_addr == A_IE_SET)),
        .clr_we(wr && (req_addr == A_IE_CLR)),
        .wdata(req_wdata), .hw_set('0), .q(ie_q)
    );

    pmu_bitmap #(.W(REG_W), .MASK(IMPL_MASK)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr && (req_addr == A_OVF_SET)),
        .clr_we(wr && (req_addr == A_OVF_CLR)),
        .wdata(req_wdata), .hw_set(hw_ovf), .q(ovf_q)
    );

    // ---------------- event counters ----------------
    logic [REG_W-1:0] typ_q [MAX_CNT];
    logic [REG_W-1:0] cnt_q [MAX_CNT];

    for (genvar i = 0; i < MAX_CNT; i++) begin : g_cnt
        if (i < NUM_CNT) begin : g_impl
            logic hit_sel, hit_dir_t, hit_dir_c;
            assign hit_sel   = (sel_q == 5'(i));
            assign hit_dir_t = (req_addr[6:5] == REGION_TYPE) && (req_addr[4:0] == 5'(i));
            assign hit_dir_c = (req_addr[6:5] == REGION_CNT)  && (req_addr[4:0] == 5'(i));

            pmu_evt_counter #(.NUM_EVT(NUM_EVT)) u_ctr (
                .clk(clk), .rst_n(rst_n),
                .type_we(wr && (hit_dir_t || (hit_sel && (req_addr == A_SEL_TYPE)))),
                .type_wval(typ_wval),
                .cnt_we(wr && (hit_dir_c || (hit_sel && (req_addr == A_SEL_CNT)))),
                .cnt_wval(req_wdata),
                .clr(ev_clr),
                .active(glob_en && en_q[i]),
                .priv_kernel(priv_kernel),
                .evt_in(evt_in),
                .type_q(typ_q[i]),
                .count_q(cnt_q[i]),
                .ovf_pulse(ovf_ev[i])
            );
        end else begin : g_absent
            assign typ_q[i]  = '0;
            assign cnt_q[i]  = '0;
            assign ovf_ev[i] = 1'b0;
        end
    end

    // ---------------- cycle counter ----------------
    logic [2*REG_W-1:0] cyc_q;

    pmu_cyc_counter u_cyc (
        .clk(clk), .rst_n(rst_n),
        .clr(cy_clr),
        .lo_we(wr && (req_addr == A_CYC_LO)),
        .hi_we(wr && (req_addr == A_CYC_HI)),
        .wval(req_wdata),
        .active(glob_en && en_q[31]),
        .long_mode(long_cyc),
        .cnt_q(cyc_q),
        .ovf_pulse(cyc_ovf)
    );

    // ---------------- read mux ----------------
    logic [REG_W-1:0] rd_val, sel_typ, sel_cnt, dir_typ, dir_cnt;

    always_comb begin
        sel_typ = '0;
        sel_cnt = '0;
        dir_typ = '0;
        dir_cnt = '0;
        for (int i = 0; i < MAX_CNT; i++) begin
            if (sel_q == 5'(i)) begin
                sel_typ = typ_q[i];
                sel_cnt = cnt_q[i];
            end
            if (req_addr[4:0] == 5'(i)) begin
                dir_typ = typ_q[i];
                dir_cnt = cnt_q[i];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (req_addr)
            A_CTRL:     rd_val = {16'b0, N_FIELD, 3'b0, 1'b0, long_cyc, 5'b0, glob_en};
            A_EN_SET,
            A_EN_CLR:   rd_val = en_q;
            A_IE_SET,
            A_IE_CLR:   rd_val = ie_q;
            A_OVF_SET,
            A_OVF_CLR:  rd_val = ovf_q;
            A_SEL:      rd_val = {27'b0, sel_q};
            A_SEL_TYPE: rd_val = sel_typ;
            A_SEL_CNT:  rd_val = sel_cnt;
            A_CYC_LO:   rd_val = cyc_q[REG_W-1:0];
            A_CYC_HI:   rd_val = cyc_q[2*REG_W-1:REG_W];
            default: begin
                if (req_addr[6:5] == REGION_TYPE)     rd_val = dir_typ;
                else if (req_addr[6:5] == REGION_CNT) rd_val = dir_cnt;
            end
        endcase
    end

    // ---------------- response state machine ----------------
    acc_state_t state_q, state_d;
    logic [REG_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_val;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ACC_RESP);
        rsp_rdata = rdata_q;
        irq       = |(ovf_q & ie_q);
    end

    // R13: every response is preceded by exactly one read request
    assert_rsp_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_req));

    // R13: a read request is always answered next cycle
    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    // R7: clearing every status bit with no new overflow drops the interrupt
    assert_irq_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (req_addr == A_OVF_CLR) && (req_wdata == '1) && (hw_ovf == '0)) |=> !irq);
endmodule

// File: tb/tb_pmu_counter_bank.sv
module tb_pmu_counter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCNT = 6;
    localparam int NEVT = 64;

    localparam logic [6:0] R_CTRL = 7'h00, R_ENS = 7'h01, R_ENC = 7'h02,
        R_IES = 7'h03, R_IEC = 7'h04, R_OVS = 7'h05, R_OVC = 7'h06,
        R_SEL = 7'h07, R_STYP = 7'h08, R_SCNT = 7'h09, R_CLO = 7'h0A, R_CHI = 7'h0B;
    localparam logic [31:0] NFLD = 32'(NCNT) << 11;
    localparam logic [31:0] IMPL = 32'h8000_003F;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [NEVT-1:0] evt_in = '0;
    logic priv_kernel = 1'b0;
    logic rsp_valid, irq;
    logic [31:0] rsp_rdata;

    pmu_counter_bank #(.NUM_CNT(NCNT), .NUM_EVT(NEVT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .evt_in(evt_in),
        .priv_kernel(priv_kernel), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic pulse(input int idx, input int n);
        @(negedge clk);
        evt_in[idx] = 1'b1;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    // monitor: compare responses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R13: unexpected response actual %h expected none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq low after reset", 32'(irq), 32'd0);
        rd(R_CTRL, NFLD, "R1 ctrl reset value");
        rd(R_ENS, 32'd0, "R1 enable bitmap reset");
        rd(R_OVS, 32'd0, "R1 overflow bitmap reset");
        rd(7'h40, 32'd0, "R1 counter 0 reset");

        // R2 control readback
        wr(R_CTRL, 32'hFFFF_FFFF);
        rd(R_CTRL, NFLD | 32'h41, "R2 ctrl all-ones readback");
        wr(R_CTRL, 32'h0);
        rd(R_CTRL, NFLD, "R2 ctrl cleared");

        // R3 enable views
        wr(R_ENS, 32'hFFFF_FFFF);
        rd(R_ENS, IMPL, "R3 set view drops unimplemented");
        rd(R_ENC, IMPL, "R3 clear view mirrors");
        wr(R_ENC, ~32'h3);
        rd(R_ENS, 32'h3, "R3 only counters 0 and 1 left");

        // R4 overflow / interrupt enable
        wr(R_OVC, 32'hFFFF_FFFF);
        rd(R_OVS, 32'd0, "R4 overflow clear");
        wr(R_IEC, 32'hFFFF_FFFF);
        rd(R_IES, 32'd0, "R4 interrupt enable cleared");
        wr(R_IES, 32'hFFFF_FFFF);
        rd(R_IEC, IMPL, "R4 interrupt enable set on implemented");

        // R8 / R9 selector access
        wr(R_SEL, 32'd1);
        wr(R_STYP, 32'h0000_00EA);
        wr(R_SCNT, 32'hDEAD_BEEF);
        rd(7'h21, 32'h0000_00EA, "R8 direct type via selector write");
        rd(7'h41, 32'hDEAD_BEEF, "R8 direct count via selector write");
        wr(7'h21, 32'hFFFF_FFFF);
        rd(R_STYP, 32'hC000_03FF, "R9 type keeps only event and exclude bits");
        wr(R_SEL, 32'd31);
        wr(R_SCNT, 32'h1111_1111);
        rd(R_SCNT, 32'd0, "R8 unimplemented index reads 0");

        // R5 / R6 counting and overflow: counters 0,1,2 all on event 3
        wr(7'h20, 32'd3); wr(7'h21, 32'd3); wr(7'h22, 32'd3);
        wr(R_CTRL, 32'h2);
        wr(7'h40, 32'hFFFF_FFF0);
        wr(R_CTRL, 32'h1);
        pulse(3, 20);
        wr(R_CTRL, 32'h0);
        rd(7'h40, 32'd4, "R6 counter 0 wrapped");
        rd(7'h41, 32'd20, "R5 counter 1 counted");
        rd(7'h42, 32'd0, "R5 disabled counter 2 held");
        rd(R_OVS, 32'h1, "R6 only counter 0 overflow");
        chk("R7 irq raised", 32'(irq), 32'd1);
        wr(R_OVC, 32'hFFFF_FFFF);
        chk("R7 irq dropped after clear", 32'(irq), 32'd0);

        // R11 event reset action
        wr(R_CTRL, 32'h2);
        rd(R_CTRL, NFLD, "R11 reset bits read 0");
        rd(7'h41, 32'd0, "R11 event counters zeroed");

        // R9 exclude filtering on counters 4 and 5
        wr(7'h24, 32'h4000_0005);
        wr(7'h25, 32'h8000_0005);
        wr(R_ENS, 32'h30);
        wr(R_CTRL, 32'h1);
        priv_kernel = 1'b0;
        pulse(5, 7);
        priv_kernel = 1'b1;
        pulse(5, 5);
        wr(R_CTRL, 32'h0);
        rd(7'h44, 32'd5, "R9 exclude-user counts only kernel");
        rd(7'h45, 32'd7, "R9 exclude-kernel counts only user");

        // R10 unsupported event number
        wr(R_SEL, 32'd2);
        wr(R_STYP, 32'h3FF);
        wr(R_SCNT, 32'h1234_5678);
        wr(R_ENS, 32'h4);
        wr(R_CTRL, 32'h1);
        @(negedge clk); evt_in = '1;
        repeat (5) @(negedge clk); evt_in = '0;
        wr(R_CTRL, 32'h0);
        rd(R_SCNT, 32'h1234_5678, "R10 unsupported event keeps written count");

        // R12 cycle counter, 32-bit wrap
        wr(R_OVC, 32'hFFFF_FFFF);
        wr(R_CTRL, 32'h4);
        rd(R_CLO, 32'd0, "R11 cycle counter zeroed");
        wr(R_CLO, 32'hFFFF_FFF0);
        wr(R_ENS, 32'h8000_0000);
        wr(R_CTRL, 32'h1);
        repeat (30) @(negedge clk);
        wr(R_CTRL, 32'h0);
        rd(R_OVS, 32'h8000_0000, "R12 short-mode overflow on bit 31");
        chk("R7 irq from cycle overflow", 32'(irq), 32'd1);

        // R12 cycle counter, long mode
        wr(R_OVC, 32'hFFFF_FFFF);
        wr(R_CTRL, 32'h44);
        wr(R_CLO, 32'hFFFF_FFF0);
        wr(R_CTRL, 32'h41);
        repeat (30) @(negedge clk);
        wr(R_CTRL, 32'h40);
        rd(R_OVS, 32'd0, "R12 long mode no overflow at 32-bit wrap");
        rd(R_CHI, 32'd1, "R12 long mode carries into high half");
        rd(R_CTRL, NFLD | 32'h40, "R2 long-cycle bit reads back");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R13: actual %0d responses missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule